// File: doc/BRIEF.md
# PCI Host Configuration and I/O Cycle Launcher

This block sits between an embedded processor's register bus and the master side of a PCI bus controller. It lets software on the processor run single configuration-space and I/O-space transfers. There are two channels, one for configuration and one for I/O, and each has its own address, data and control register. Software loads the address, and for a write also the data. A write to the channel's control register then starts the transfer. Only one transfer can be outstanding across both channels.

While a transfer runs, the block holds a level request towards the bus controller. Alongside it the block drives the address, the active-low byte-lane enables, the direction and the write data. The controller answers with a one-cycle completion strobe, which carries read data for a read. On completion the block clears the channel's busy flag and sets its done flag. For a read it also keeps the returned word in the channel's data register. If the channel's interrupt enable is set, the interrupt line goes high until software clears done by writing 1 to it. Two sticky error bits are kept. One records a launch attempt made while a transfer was outstanding. The other records a configuration launch whose device-select field did not have exactly one bit set.

Register offsets (word index): 0 config address, 1 config data, 2 config control, 3 I/O address, 4 I/O data, 5 I/O control, 6 status. Offset 7 reads as zero.

Top module: `pci_hc_ctl`

## Requirements
- R1: After reset, every register reads zero, `bus_req` and `irq` are low, `bus_cbe_n` is 4'hF, and `bus_addr`, `bus_rd` and `bus_wdata` are zero.
- R2: A write to a control register (offset 2 for config, 5 for I/O) while no transfer is outstanding stores bits 5:0 and starts a transfer. From the next cycle `bus_req` is high and `bus_is_io` is 1 for the I/O channel and 0 for the config channel. The two channels are never busy together.
- R3: While `bus_req` is high, the bus side reflects the active channel. `bus_addr` equals its address register, with the config function-number field (bits 10:8) passed through unchanged. `bus_cbe_n` equals control bits 3:0, where 0 means the byte lane takes part and bit 0 is the least significant lane. `bus_rd` equals control bit 4 (1 read, 0 write). `bus_wdata` equals its data register. While `bus_req` is low, the bus outputs are zero and `bus_cbe_n` is 4'hF.
- R4: When a read completes, `bus_rdata` is stored into that channel's data register. When a write completes, the data register keeps its value.
- R5: On a `bus_ack` during a transfer, the busy flag clears and the done flag sets at the same edge, so `bus_req` is low in the next cycle. A `bus_ack` with no transfer outstanding has no effect.
- R6: Status layout: bit 0 config busy, bit 1 config done, bit 2 I/O busy, bit 3 I/O done, bit 4 overlap error, bit 5 device-select error. Writing 1 to a done or error bit clears it, and writing 0 leaves it. A set in the same cycle wins over the clear.
- R7: `irq` equals (config done AND config control bit 5) OR (I/O done AND I/O control bit 5).
- R8: A control write while either busy flag is set is ignored: the control register, the running transfer and the bus outputs are unchanged. Status bit 4 is set and stays set until cleared.
- R9: A config launch whose address bits 31:11 do not have exactly one bit set still runs as a transfer, and it sets status bit 5.
- R10: Address and data registers read back the last value written, and control registers read back their stored bits 5:0 with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_ofs | input | 3 | Register write offset |
| reg_wr_val | input | 32 | Register write value |
| reg_rd_ofs | input | 3 | Register read offset |
| reg_rd_val | output | 32 | Register read value (combinational) |
| bus_req | output | 1 | Transfer request, high while a transfer is outstanding |
| bus_is_io | output | 1 | 1 for I/O space, 0 for configuration space |
| bus_addr | output | 32 | Transfer address |
| bus_cbe_n | output | 4 | Active-low byte-lane enables |
| bus_rd | output | 1 | 1 read, 0 write |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Completion strobe, one cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| irq | output | 1 | Completion interrupt |

## Verification
A stuck busy flag shows up on `bus_req` in the cycle after the acknowledge. It also blocks the next launch, so the status read and the bus outputs diverge from the model one cycle after the next control write. A lost capture or a wrong direction bit is visible on the data readback at the first read of that offset after completion, because the bench sweeps the read offset every cycle. A wrong enable or done bit flips `irq` in the cycle after the completion edge or after the W1C write. A missed overlap or device-select error shows up in the status word within eight cycles.

// File: rtl/pci_hc_pkg.sv
package pci_hc_pkg;

  localparam int unsigned OFS_W   = 3;
  localparam int unsigned N_CH    = 2;
  localparam int unsigned CH_CFG  = 0;
  localparam int unsigned CH_IO   = 1;

  localparam int unsigned CTL_W      = 6;
  localparam int unsigned CTL_BE_W   = 4;
  localparam int unsigned CTL_DIR    = 4;
  localparam int unsigned CTL_IE     = 5;

  localparam int unsigned ERR_N      = 2;
  localparam int unsigned ST_ERR_LO  = 2 * N_CH;

  typedef enum logic [OFS_W-1:0] {
    OFS_CFG_ADDR = 3'd0,
    OFS_CFG_DATA = 3'd1,
    OFS_CFG_CTL  = 3'd2,
    OFS_IO_ADDR  = 3'd3,
    OFS_IO_DATA  = 3'd4,
    OFS_IO_CTL   = 3'd5,
    OFS_STATUS   = 3'd6,
    OFS_NONE     = 3'd7
  } reg_ofs_e;

  typedef enum logic [1:0] { KIND_ADDR = 2'd0, KIND_DATA = 2'd1, KIND_CTL = 2'd2 } reg_kind_e;

  function automatic logic [OFS_W-1:0] ch_ofs(input int unsigned ch, input reg_kind_e kind);
    return OFS_W'(ch * 3 + int'(kind));
  endfunction

endpackage

// File: rtl/hc_rst_sync.sv
module hc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/hc_chan.sv
module hc_chan #(
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 6,
  parameter int unsigned DIR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_data,
  input  logic          launch,
  input  logic          done_clr,
  input  logic          cyc_end,
  input  logic [DW-1:0] wr_val,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic [CW-1:0] ctl_q,
  output logic          busy_q,
  output logic          done_q
);

  logic [DW-1:0] addr_d, data_d;
  logic [CW-1:0] ctl_d;
  logic          busy_d, done_d;
  logic          addr_en, data_en, ctl_en, flag_en;
  logic          capture;

  always_comb begin
    capture = cyc_end & ctl_q[DIR];
    addr_en = ld_addr;
    data_en = ld_data | capture;
    ctl_en  = launch;
    flag_en = launch | cyc_end | done_clr;

    addr_d  = wr_val;
    data_d  = capture ? rdata : wr_val;
    ctl_d   = wr_val[CW-1:0];

    busy_d  = busy_q;
    done_d  = done_q;
    if (done_clr) done_d = 1'b0;
    if (launch)   busy_d = 1'b1;
    if (cyc_end) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      ctl_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (data_en) data_q <= data_d;
      if (ctl_en)  ctl_q  <= ctl_d;
      if (flag_en) begin
        busy_q <= busy_d;
        done_q <= done_d;
      end
    end
  end

endmodule

// File: rtl/hc_sticky.sv
module hc_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);

  logic [N-1:0] flag_d;
  logic         flag_en;

  always_comb begin
    flag_d  = (flag_q & ~clr) | set;
    flag_en = |(set | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/pci_hc_ctl.sv
module pci_hc_ctl
  import pci_hc_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned DSEL_LO = 11,
  parameter int unsigned DSEL_W  = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [OFS_W-1:0] reg_wr_ofs,
  input  logic [DW-1:0]    reg_wr_val,
  input  logic [OFS_W-1:0] reg_rd_ofs,
  output logic [DW-1:0]    reg_rd_val,
  output logic             bus_req,
  output logic             bus_is_io,
  output logic [DW-1:0]    bus_addr,
  output logic [3:0]       bus_cbe_n,
  output logic             bus_rd,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ack,
  input  logic [DW-1:0]    bus_rdata,
  output logic             irq
);

  localparam int unsigned DSEL_HI = DSEL_LO + DSEL_W - 1;
  localparam int unsigned CNT_W   = $clog2(DSEL_W + 1);
  localparam int unsigned ST_W    = ST_ERR_LO + ERR_N;

  logic                rst_q_n;
  logic [DW-1:0]       ch_addr [N_CH];
  logic [DW-1:0]       ch_data [N_CH];
  logic [CTL_W-1:0]    ch_ctl  [N_CH];
  logic [N_CH-1:0]     ch_busy;
  logic [N_CH-1:0]     ch_done;
  logic [N_CH-1:0]     ctl_wr;
  logic [N_CH-1:0]     launch;
  logic [N_CH-1:0]     cyc_end;
  logic [N_CH-1:0]     done_clr;
  logic [N_CH-1:0]     irq_src;
  logic [ERR_N-1:0]    err_set, err_clr, err_q;
  logic                any_busy;
  logic                st_wr;
  logic [CNT_W-1:0]    dsel_cnt;
  logic                dsel_bad;
  logic [ST_W-1:0]     status;
  logic                sel;

  hc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign any_busy = |ch_busy;
  assign st_wr    = reg_wr && (reg_wr_ofs == OFS_STATUS);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ctl_wr[c]   = reg_wr && (reg_wr_ofs == ch_ofs(c, KIND_CTL));
    assign launch[c]   = ctl_wr[c] && !any_busy;
    assign cyc_end[c]  = bus_ack && ch_busy[c];
    assign done_clr[c] = st_wr && reg_wr_val[2*c+1];
    assign irq_src[c]  = ch_done[c] && ch_ctl[c][CTL_IE];
    assign status[2*c]   = ch_busy[c];
    assign status[2*c+1] = ch_done[c];

    hc_chan #(.DW(DW), .CW(CTL_W), .DIR(CTL_DIR)) u_chan (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .ld_addr  (reg_wr && (reg_wr_ofs == ch_ofs(c, KIND_ADDR))),
      .ld_data  (reg_wr && (reg_wr_ofs == ch_ofs(c, KIND_DATA))),
      .launch   (launch[c]),
      .done_clr (done_clr[c]),
      .cyc_end  (cyc_end[c]),
      .wr_val   (reg_wr_val),
      .rdata    (bus_rdata),
      .addr_q   (ch_addr[c]),
      .data_q   (ch_data[c]),
      .ctl_q    (ch_ctl[c]),
      .busy_q   (ch_busy[c]),
      .done_q   (ch_done[c])
    );
  end

  always_comb begin
    dsel_cnt = '0;
    for (int b = DSEL_LO; b <= DSEL_HI; b++) begin
      dsel_cnt = dsel_cnt + CNT_W'(ch_addr[CH_CFG][b]);
    end
    dsel_bad = launch[CH_CFG] && (dsel_cnt != CNT_W'(1));
  end

  always_comb begin
    err_set = {dsel_bad, (|ctl_wr) && any_busy};
    err_clr = st_wr ? reg_wr_val[ST_ERR_LO +: ERR_N] : '0;
  end

  hc_sticky #(.N(ERR_N)) u_err (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set    (err_set),
    .clr    (err_clr),
    .flag_q (err_q)
  );

  assign status[ST_ERR_LO +: ERR_N] = err_q;

  always_comb begin
    sel       = ch_busy[CH_IO];
    bus_req   = any_busy;
    bus_is_io = ch_busy[CH_IO];
    bus_addr  = '0;
    bus_wdata = '0;
    bus_rd    = 1'b0;
    bus_cbe_n = '1;
    if (any_busy) begin
      bus_addr  = ch_addr[sel];
      bus_wdata = ch_data[sel];
      bus_rd    = ch_ctl[sel][CTL_DIR];
      bus_cbe_n = ch_ctl[sel][CTL_BE_W-1:0];
    end
    irq = |irq_src;
  end

  always_comb begin
    reg_rd_val = '0;
    case (reg_rd_ofs)
      OFS_CFG_ADDR: reg_rd_val = ch_addr[CH_CFG];
      OFS_CFG_DATA: reg_rd_val = ch_data[CH_CFG];
      OFS_CFG_CTL:  reg_rd_val = DW'(ch_ctl[CH_CFG]);
      OFS_IO_ADDR:  reg_rd_val = ch_addr[CH_IO];
      OFS_IO_DATA:  reg_rd_val = ch_data[CH_IO];
      OFS_IO_CTL:   reg_rd_val = DW'(ch_ctl[CH_IO]);
      OFS_STATUS:   reg_rd_val = DW'(status);
      default:      reg_rd_val = '0;
    endcase
  end

endmodule

// File: rtl/hc_chk.sv
module hc_chk
  import pci_hc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rst_int_n,
  input logic             reg_wr,
  input logic [OFS_W-1:0] reg_wr_ofs,
  input logic             bus_req,
  input logic             bus_ack,
  input logic             bus_is_io,
  input logic [3:0]       bus_cbe_n,
  input logic             bus_rd,
  input logic             irq,
  input logic [N_CH-1:0]  busy,
  input logic [N_CH-1:0]  done
);

  logic ctl_hit;
  assign ctl_hit = reg_wr && ((reg_wr_ofs == OFS_CFG_CTL) || (reg_wr_ofs == OFS_IO_CTL));

  AST_LAUNCH_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    ctl_hit && !bus_req |=> bus_req); // R2

  AST_ONE_CHANNEL_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    !(busy[0] && busy[1])); // R2

  AST_IDLE_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    !bus_req |-> (bus_cbe_n == 4'hF) && !bus_rd); // R3

  AST_ACK_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    bus_req && bus_ack |=> !bus_req && (done != '0)); // R5

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    irq |-> (done != '0)); // R7

  AST_BUSY_HOLDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_cbe_n) && $stable(bus_rd) && $stable(bus_is_io)); // R8

endmodule

bind pci_hc_ctl hc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_int_n  (rst_q_n),
  .reg_wr     (reg_wr),
  .reg_wr_ofs (reg_wr_ofs),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .bus_is_io  (bus_is_io),
  .bus_cbe_n  (bus_cbe_n),
  .bus_rd     (bus_rd),
  .irq        (irq),
  .busy       (ch_busy),
  .done       (ch_done)
);

// File: tb/test_pci_hc_ctl.sv
module test_pci_hc_ctl;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_wr_ofs = '0;
  logic [31:0] reg_wr_val = '0;
  logic [2:0]  reg_rd_ofs = '0;
  logic [31:0] reg_rd_val;
  logic        bus_req, bus_is_io, bus_rd, irq;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_cbe_n;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;
  int rd_cnt = 0;

  // reference model state
  logic [31:0] m_addr [2];
  logic [31:0] m_data [2];
  logic [5:0]  m_ctl  [2];
  bit          m_busy [2];
  bit          m_done [2];
  bit          m_ecol, m_edsel;

  always #2.5 clk = ~clk;

  pci_hc_ctl i_pci_hc_ctl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_wr_ofs(reg_wr_ofs), .reg_wr_val(reg_wr_val),
    .reg_rd_ofs(reg_rd_ofs), .reg_rd_val(reg_rd_val),
    .bus_req(bus_req), .bus_is_io(bus_is_io), .bus_addr(bus_addr),
    .bus_cbe_n(bus_cbe_n), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_addr[c] = '0; m_data[c] = '0; m_ctl[c] = '0;
      m_busy[c] = 0;  m_done[c] = 0;
    end
    m_ecol = 0; m_edsel = 0;
  endtask

  // R2 R4 R5 R6 R8 R9: model advances once per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit any;
      bit pre_busy [2];
      any = m_busy[0] | m_busy[1];
      pre_busy[0] = m_busy[0];
      pre_busy[1] = m_busy[1];
      if (reg_wr) begin
        case (reg_wr_ofs)
          3'd0: m_addr[0] = reg_wr_val;
          3'd1: m_data[0] = reg_wr_val;
          3'd3: m_addr[1] = reg_wr_val;
          3'd4: m_data[1] = reg_wr_val;
          3'd6: begin
            if (reg_wr_val[1]) m_done[0] = 0;
            if (reg_wr_val[3]) m_done[1] = 0;
            if (reg_wr_val[4]) m_ecol = 0;
            if (reg_wr_val[5]) m_edsel = 0;
          end
          3'd2, 3'd5: begin
            int c;
            c = (reg_wr_ofs == 3'd5) ? 1 : 0;
            if (any) m_ecol = 1;
            else begin
              m_ctl[c]  = reg_wr_val[5:0];
              m_busy[c] = 1;
              if (c == 0 && $countones(m_addr[0][31:11]) != 1) m_edsel = 1;
            end
          end
          default: ;
        endcase
      end
      for (int c = 0; c < 2; c++) begin
        if (bus_ack && pre_busy[c]) begin
          if (m_ctl[c][4]) m_data[c] = bus_rdata;
          m_busy[c] = 0;
          m_done[c] = 1;
        end
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] ofs);
    case (ofs)
      3'd0: return m_addr[0];
      3'd1: return m_data[0];
      3'd2: return {26'b0, m_ctl[0]};
      3'd3: return m_addr[1];
      3'd4: return m_data[1];
      3'd5: return {26'b0, m_ctl[1]};
      3'd6: return {26'b0, m_edsel, m_ecol, m_done[1], m_busy[1], m_done[0], m_busy[0]};
      default: return '0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every output against the model at each falling edge
  always @(negedge clk) begin
    bit req;
    int s;
    req = m_busy[0] | m_busy[1];
    s   = m_busy[1] ? 1 : 0;
    cmp("R2", "bus_req", 32'(bus_req), 32'(req));
    cmp("R2", "bus_is_io", 32'(bus_is_io), 32'(m_busy[1]));
    cmp("R3", "bus_addr", bus_addr, req ? m_addr[s] : 32'h0);
    cmp("R3", "bus_cbe_n", 32'(bus_cbe_n), req ? 32'(m_ctl[s][3:0]) : 32'hF);
    cmp("R3", "bus_rd", 32'(bus_rd), req ? 32'(m_ctl[s][4]) : 32'h0);
    cmp("R3", "bus_wdata", bus_wdata, req ? m_data[s] : 32'h0);
    cmp("R7", "irq", 32'(irq), 32'((m_done[0] & m_ctl[0][5]) | (m_done[1] & m_ctl[1][5])));
    cmp("R10 R4 R6", "reg_rd_val", reg_rd_val, model_rd(reg_rd_ofs));
  end

  task automatic drive(input bit wr, input logic [2:0] ofs, input logic [31:0] val,
                       input bit ack, input logic [31:0] rdata);
    @(negedge clk);
    #1;
    reg_wr = wr; reg_wr_ofs = ofs; reg_wr_val = val;
    bus_ack = ack; bus_rdata = rdata;
    reg_rd_ofs = 3'(rd_cnt);
    rd_cnt++;
  endtask

  task automatic wr(input logic [2:0] ofs, input logic [31:0] val);
    drive(1, ofs, val, 0, 32'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 3'd0, 32'h0, 0, 32'h0);
  endtask

  task automatic ack(input logic [31:0] rdata);
    drive(0, 3'd0, 32'h0, 1, rdata);
  endtask

  // explicit check of one register at a chosen offset, literal expectation
  task automatic peek(input logic [2:0] ofs, input logic [31:0] exp, input string tag);
    @(negedge clk);
    #1;
    reg_wr = 0; bus_ack = 0; reg_rd_ofs = ofs;
    @(negedge clk);
    cmp(tag, "peek", reg_rd_val, exp);
  endtask

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(6);

    // R1: reset state
    peek(3'd6, 32'h0, "R1");
    peek(3'd2, 32'h0, "R1");
    cmp("R1", "irq", 32'(irq), 32'h0);

    // R2 R3 R7: config write, function 5, device bit 3, all bytes, irq enabled
    wr(3'd0, 32'h0000_4000 | (32'd5 << 8) | 32'h10);
    wr(3'd1, 32'hA5A5_0F0F);
    wr(3'd2, 32'h20);
    idle(3);
    peek(3'd6, 32'h1, "R2");
    cmp("R3", "fn field", 32'(bus_addr[10:8]), 32'd5);
    ack(32'hDEAD_BEEF);
    idle(1);
    cmp("R5", "req after ack", 32'(bus_req), 32'h0);
    cmp("R7", "irq on done", 32'(irq), 32'h1);
    peek(3'd1, 32'hA5A5_0F0F, "R4");
    // R6: writing 0 leaves done; writing 1 clears it
    wr(3'd6, 32'h0);
    peek(3'd6, 32'h2, "R6");
    wr(3'd6, 32'h2);
    peek(3'd6, 32'h0, "R6");
    cmp("R7", "irq cleared", 32'(irq), 32'h0);

    // R4 R3: config read, lanes 1 and 3 off, irq disabled
    wr(3'd2, 32'h1A);
    idle(2);
    cmp("R3", "cbe", 32'(bus_cbe_n), 32'hA);
    ack(32'h1234_5678);
    idle(1);
    cmp("R7", "irq masked", 32'(irq), 32'h0);
    peek(3'd1, 32'h1234_5678, "R4");
    wr(3'd6, 32'h2);

    // R5: ack with nothing outstanding does nothing
    ack(32'hFFFF_FFFF);
    peek(3'd6, 32'h0, "R5");
    peek(3'd1, 32'h1234_5678, "R5");

    // R8: I/O read running, config control write and I/O control write ignored
    wr(3'd3, 32'h0000_0CF8);
    wr(3'd5, 32'h30);
    idle(1);
    wr(3'd2, 32'h3F);
    wr(3'd5, 32'h0F);
    peek(3'd5, 32'h30, "R8");
    peek(3'd2, 32'h1A, "R8");
    cmp("R8", "is_io", 32'(bus_is_io), 32'h1);
    peek(3'd6, 32'h14, "R8");
    // collision in the ack cycle also ignored
    drive(1, 3'd2, 32'h00, 1, 32'hCAFE_F00D);
    idle(1);
    peek(3'd6, 32'h18, "R8");
    peek(3'd4, 32'hCAFE_F00D, "R4");
    cmp("R7", "io irq", 32'(irq), 32'h1);
    wr(3'd6, 32'h18);
    peek(3'd6, 32'h0, "R6");

    // R9: two device bits set, cycle still runs
    wr(3'd0, 32'h0001_8000);
    wr(3'd2, 32'h00);
    idle(1);
    cmp("R9", "req runs", 32'(bus_req), 32'h1);
    ack(32'h0);
    idle(1);
    peek(3'd6, 32'h22, "R9");
    // R9: zero device bits, plus clear-vs-set same cycle
    wr(3'd6, 32'h22);
    wr(3'd0, 32'h0000_0100);
    wr(3'd2, 32'h10);
    idle(2);
    drive(1, 3'd6, 32'h2, 1, 32'h5555_AAAA);
    idle(1);
    peek(3'd6, 32'h22, "R6");
    peek(3'd1, 32'h5555_AAAA, "R4");
    wr(3'd6, 32'h3F);
    peek(3'd6, 32'h0, "R9");

    // R10: readback of I/O registers, upper control bits dropped
    wr(3'd4, 32'h0BAD_F00D);
    wr(3'd3, 32'h7777_0000);
    peek(3'd3, 32'h7777_0000, "R10");
    peek(3'd4, 32'h0BAD_F00D, "R10");
    peek(3'd7, 32'h0, "R10");
    // R4: write transfer leaves data untouched
    wr(3'd5, 32'hFFFF_FFC3);
    peek(3'd5, 32'h03, "R10");
    ack(32'h1111_1111);
    idle(1);
    peek(3'd4, 32'h0BAD_F00D, "R4");
    idle(8);

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule